// File: doc/BRIEF.md
# Arbiter Command Channel Sequencer

This block is the register front-end of one channel of a power-management serial bus arbiter. Software loads up to eight bytes of write data into two 32-bit data registers, then writes a command word carrying an opcode, a 4-bit slave ID, a 16-bit register address and a byte count. The block checks the opcode, then either completes at once with an error or hands one transaction to a request/acknowledge backend that stands in for the serial bus. When the backend acknowledges, the block records the outcome in a 4-bit status register. For read opcodes it keeps the returned bytes in two read-data registers.

The sequencer has two states. SEQ_IDLE moves to SEQ_WAIT on a command write with a known opcode (transition ACCEPT). SEQ_IDLE stays put on a command write with an unknown opcode (transition REJECT), which completes at once with a failure. SEQ_WAIT stays put on a command write (transition DROP), which flags the new command as dropped. SEQ_WAIT returns to SEQ_IDLE when the backend acknowledges (transition FINISH).

Register reads are combinational from `reg_addr`. Writes take effect at the rising clock edge when `reg_wen` is high.

Top module: `cmd_chan_seq`

## Requirements
- R1: Register byte offsets are: 0x00 command, 0x04 config, 0x08 status, 0x10 write data word 0, 0x14 write data word 1, 0x18 read data word 0, 0x1C read data word 1. Config is a plain 32-bit read/write register. Unmapped offsets read as zero.
- R2: Command word layout: opcode in bits 31:27, slave ID in bits 23:20, address in bits 19:4, byte count minus one in bits 2:0. Once the command is accepted, these fields appear on the backend port. The command register reads back the last word written while idle.
- R3: Known opcodes: writes are 0, 2, 14 and 16; reads are 1, 13 and 15. A command with any other opcode raises no backend request and leaves status 0x3 (done and failure) one cycle after the write.
- R4: Status bit 0 is done, bit 1 is failure, bit 2 is denied and bit 3 is dropped. A command write in SEQ_IDLE clears status. The acknowledge sets done, sets failure for result 1 or 3, sets denied for result 2, and leaves dropped as it was.
- R5: Write data is little-endian: byte k sits in bits 8k+7:8k of the 64-bit value {word1, word0}. Bytes above the byte count are zero on `be_wdata`, so word 1 contributes only when more than four bytes are sent.
- R6: On an acknowledge with result 0 for a read opcode, the returned bytes up to the byte count are written into the read-data registers in the same cycle, and higher bytes become zero. Failed or denied reads, and writes, leave the read-data registers unchanged.
- R7: A command write during SEQ_WAIT does not change the backend fields. It sets done and dropped in status on the next cycle.
- R8: `be_valid` and all backend fields hold steady from acceptance until the acknowledge cycle. `be_valid` is low on the cycle after the acknowledge.
- R9: After reset, status, config, both read-data registers and `be_valid` are zero.
- R10: Register writes to the status or read-data offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| be_valid | output | 1 | Backend request pending |
| be_op | output | 5 | Transaction opcode |
| be_sid | output | 4 | Slave ID |
| be_addr | output | 16 | Slave register address |
| be_bcnt | output | 3 | Byte count minus one |
| be_wdata | output | 64 | Packed write bytes, unused bytes zero |
| be_ack | input | 1 | Backend acknowledge, one cycle |
| be_result | input | 2 | Outcome: 0 ok, 1 fail, 2 deny, 3 fail |
| be_rdata | input | 64 | Returned read bytes, valid with be_ack |

## Verification
The assertions assume that `be_ack` is only ever high while `be_valid` is high, and only for one cycle per request. They also assume that `be_result` and `be_rdata` are meaningful only during that acknowledge cycle. The bench responder waits for `be_valid`, holds off for a chosen number of cycles, then pulses `be_ack` for exactly one cycle. Register writes are issued one at a time, so a command write and an acknowledge never share a cycle. The dropped-command case is provoked by writing a second command while the responder is still holding off.

// File: rtl/cmd_chan_pkg.sv
package cmd_chan_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    localparam int OP_W   = 5;
    localparam int SID_W  = 4;
    localparam int RADR_W = 16;
    localparam int BCF_W  = 3;

    localparam int OP_LSB   = 27;
    localparam int SID_LSB  = 20;
    localparam int RADR_LSB = 4;
    localparam int BC_LSB   = 0;

    localparam logic [OP_W-1:0] OPC_EXTL_WR = 5'd0;
    localparam logic [OP_W-1:0] OPC_EXTL_RD = 5'd1;
    localparam logic [OP_W-1:0] OPC_EXT_WR  = 5'd2;
    localparam logic [OP_W-1:0] OPC_EXT_RD  = 5'd13;
    localparam logic [OP_W-1:0] OPC_WR      = 5'd14;
    localparam logic [OP_W-1:0] OPC_RD      = 5'd15;
    localparam logic [OP_W-1:0] OPC_ZERO_WR = 5'd16;

    localparam logic [1:0] RES_OK   = 2'd0;
    localparam logic [1:0] RES_FAIL = 2'd1;
    localparam logic [1:0] RES_DENY = 2'd2;

    localparam int STB_DONE = 0;
    localparam int STB_FAIL = 1;
    localparam int STB_DENY = 2;
    localparam int STB_DROP = 3;
    localparam int STAT_W   = 4;

    localparam int OFS_CMD  = 'h00;
    localparam int OFS_CFG  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_WD0  = 'h10;
    localparam int OFS_WD1  = 'h14;
    localparam int OFS_RD0  = 'h18;
    localparam int OFS_RD1  = 'h1C;

endpackage

// File: rtl/cmd_chan_opdec.sv
module cmd_chan_opdec
    import cmd_chan_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output logic            known,
    output logic            is_read
);

    always_comb begin
        known   = 1'b1;
        is_read = 1'b0;
        case (opcode)
            OPC_EXTL_RD, OPC_EXT_RD, OPC_RD:             is_read = 1'b1;
            OPC_EXTL_WR, OPC_EXT_WR, OPC_WR, OPC_ZERO_WR: is_read = 1'b0;
            default:                                      known   = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmd_chan_fsm.sv
module cmd_chan_fsm
    import cmd_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic op_known,
    input  logic be_ack,
    output logic busy,
    output logic accept,
    output logic reject,
    output logic drop,
    output logic finish
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (cmd_wr && op_known) state_d = SEQ_WAIT;
            SEQ_WAIT: if (be_ack)             state_d = SEQ_IDLE;
            default:                          state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy   = (state_q == SEQ_WAIT);
        accept = cmd_wr && (state_q == SEQ_IDLE) && op_known;
        reject = cmd_wr && (state_q == SEQ_IDLE) && !op_known;
        drop   = cmd_wr && (state_q == SEQ_WAIT);
        finish = be_ack && (state_q == SEQ_WAIT);
    end

    // R8: request stays up until acknowledged
    a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !be_ack |=> busy);
    // R8: request released after acknowledge
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        busy && be_ack |=> !busy);
    // R3: unknown opcode raises no request
    a_r3_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !busy);

endmodule

// File: rtl/cmd_chan_seq.sv
module cmd_chan_seq
    import cmd_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wen,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  be_valid,
    output logic [OP_W-1:0]       be_op,
    output logic [SID_W-1:0]      be_sid,
    output logic [RADR_W-1:0]     be_addr,
    output logic [BCF_W-1:0]      be_bcnt,
    output logic [2*DATA_W-1:0]   be_wdata,
    input  logic                  be_ack,
    input  logic [1:0]            be_result,
    input  logic [2*DATA_W-1:0]   be_rdata
);

    localparam int NBYTES = (2 * DATA_W) / 8;
    localparam int PAIR_W = 2 * DATA_W;

    logic [DATA_W-1:0] cfg_q, cmd_q, wd0_q, wd1_q, rd0_q, rd1_q;
    logic [STAT_W-1:0] status_q, status_d;
    logic [OP_W-1:0]   t_op;
    logic [SID_W-1:0]  t_sid;
    logic [RADR_W-1:0] t_addr;
    logic [BCF_W-1:0]  t_bc;
    logic              t_read;
    logic [PAIR_W-1:0] t_wdata;

    logic [OP_W-1:0]   in_op;
    logic [SID_W-1:0]  in_sid;
    logic [RADR_W-1:0] in_addr;
    logic [BCF_W-1:0]  in_bc;
    logic              in_known, in_read;
    logic              cmd_wr, busy, accept, reject, drop, finish;
    logic [PAIR_W-1:0] wd_pair, wd_masked, rd_masked;
    logic [NBYTES-1:0] new_keep, txn_keep;

    assign in_op   = reg_wdata[OP_LSB +: OP_W];
    assign in_sid  = reg_wdata[SID_LSB +: SID_W];
    assign in_addr = reg_wdata[RADR_LSB +: RADR_W];
    assign in_bc   = reg_wdata[BC_LSB +: BCF_W];
    assign cmd_wr  = reg_wen && (reg_addr == ADDR_W'(OFS_CMD));
    assign wd_pair = {wd1_q, wd0_q};

    cmd_chan_opdec u_dec (
        .opcode (in_op),
        .known  (in_known),
        .is_read(in_read)
    );

    cmd_chan_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .op_known(in_known),
        .be_ack  (be_ack),
        .busy    (busy),
        .accept  (accept),
        .reject  (reject),
        .drop    (drop),
        .finish  (finish)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign new_keep[b] = (b <= int'(in_bc));
        assign txn_keep[b] = (b <= int'(t_bc));
        assign wd_masked[b*8 +: 8] = new_keep[b] ? wd_pair[b*8 +: 8]  : 8'h00;
        assign rd_masked[b*8 +: 8] = txn_keep[b] ? be_rdata[b*8 +: 8] : 8'h00;
    end

    always_comb begin
        status_d = status_q;
        if (accept) status_d = '0;
        if (reject) status_d = STAT_W'((1 << STB_DONE) | (1 << STB_FAIL));
        if (drop) begin
            status_d[STB_DONE] = 1'b1;
            status_d[STB_DROP] = 1'b1;
        end
        if (finish) begin
            status_d[STB_DONE] = 1'b1;
            status_d[STB_FAIL] = be_result[0];
            status_d[STB_DENY] = (be_result == RES_DENY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cmd_q    <= '0;
            wd0_q    <= '0;
            wd1_q    <= '0;
            rd0_q    <= '0;
            rd1_q    <= '0;
            status_q <= '0;
            t_op     <= '0;
            t_sid    <= '0;
            t_addr   <= '0;
            t_bc     <= '0;
            t_read   <= 1'b0;
            t_wdata  <= '0;
        end else begin
            status_q <= status_d;
            if (reg_wen && reg_addr == ADDR_W'(OFS_CFG)) cfg_q <= reg_wdata;
            if (reg_wen && reg_addr == ADDR_W'(OFS_WD0)) wd0_q <= reg_wdata;
            if (reg_wen && reg_addr == ADDR_W'(OFS_WD1)) wd1_q <= reg_wdata;
            if (accept || reject) cmd_q <= reg_wdata;
            if (accept) begin
                t_op    <= in_op;
                t_sid   <= in_sid;
                t_addr  <= in_addr;
                t_bc    <= in_bc;
                t_read  <= in_read;
                t_wdata <= wd_masked;
            end
            if (finish && t_read && be_result == RES_OK) begin
                rd0_q <= rd_masked[DATA_W-1:0];
                rd1_q <= rd_masked[PAIR_W-1:DATA_W];
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(OFS_CMD):  reg_rdata = cmd_q;
            ADDR_W'(OFS_CFG):  reg_rdata = cfg_q;
            ADDR_W'(OFS_STAT): reg_rdata = DATA_W'(status_q);
            ADDR_W'(OFS_WD0):  reg_rdata = wd0_q;
            ADDR_W'(OFS_WD1):  reg_rdata = wd1_q;
            ADDR_W'(OFS_RD0):  reg_rdata = rd0_q;
            ADDR_W'(OFS_RD1):  reg_rdata = rd1_q;
            default:           reg_rdata = '0;
        endcase
    end

    assign be_valid = busy;
    assign be_op    = t_op;
    assign be_sid   = t_sid;
    assign be_addr  = t_addr;
    assign be_bcnt  = t_bc;
    assign be_wdata = t_wdata;

    // R4: acknowledge always completes with done
    a_r4_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && be_ack |=> status_q[STB_DONE]);
    // R4: failure and denied never both set
    a_r4_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_q[STB_FAIL] && status_q[STB_DENY]));
    // R7: command during flight is flagged dropped
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && be_valid |=> status_q[STB_DROP] && status_q[STB_DONE]);
    // R8: backend fields steady while waiting
    a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid && !be_ack |=> $stable(be_op) && $stable(be_addr)
            && $stable(be_sid) && $stable(be_bcnt) && $stable(be_wdata));
    // R10: status writes have no effect
    a_r10_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen && reg_addr == ADDR_W'(OFS_STAT) && !(be_valid && be_ack)
            |=> $stable(status_q));
    // R6: read data only moves on an acknowledge
    a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(be_valid && be_ack) |=> $stable(rd0_q) && $stable(rd1_q));

endmodule

// File: tb/cmd_chan_seq_tb_top.sv
module cmd_chan_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        be_valid;
    logic [4:0]  be_op;
    logic [3:0]  be_sid;
    logic [15:0] be_addr;
    logic [2:0]  be_bcnt;
    logic [63:0] be_wdata;
    logic        be_ack = 1'b0;
    logic [1:0]  be_result = '0;
    logic [63:0] be_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cmd_chan_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .be_valid(be_valid), .be_op(be_op), .be_sid(be_sid),
        .be_addr(be_addr), .be_bcnt(be_bcnt), .be_wdata(be_wdata),
        .be_ack(be_ack), .be_result(be_result), .be_rdata(be_rdata)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit op_ok(input logic [4:0] op);
        return op inside {5'd0, 5'd1, 5'd2, 5'd13, 5'd14, 5'd15, 5'd16};
    endfunction

    function automatic bit op_rd(input logic [4:0] op);
        return op inside {5'd1, 5'd13, 5'd15};
    endfunction

    function automatic logic [63:0] keep_bytes(input logic [63:0] v, input int bc);
        logic [63:0] r = '0;
        for (int i = 0; i <= bc; i++) r[i*8 +: 8] = v[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mk(input int op, input int sid, input int adr, input int bc);
        return {op[4:0], 3'b000, sid[3:0], adr[15:0], 1'b0, bc[2:0]};
    endfunction

    // behavioural reference model
    logic        m_busy;
    logic [3:0]  m_st;
    logic [31:0] m_rd0, m_rd1, m_wd0, m_wd1;
    logic [4:0]  m_op;
    logic [3:0]  m_sid;
    logic [15:0] m_adr;
    int          m_bc;
    logic [63:0] m_wd;

    always @(posedge clk or negedge rst_n) begin : model
        logic [3:0] ns;
        logic       nb;
        if (!rst_n) begin
            m_busy = 0; m_st = 0; m_rd0 = 0; m_rd1 = 0; m_wd0 = 0; m_wd1 = 0;
            m_op = 0; m_sid = 0; m_adr = 0; m_bc = 0; m_wd = 0;
        end else begin
            ns = m_st;
            nb = m_busy;
            if (reg_wen && reg_addr == 5'h00) begin
                if (m_busy) ns = ns | 4'h9;
                else if (op_ok(reg_wdata[31:27])) begin
                    ns = 0; nb = 1;
                    m_op = reg_wdata[31:27]; m_sid = reg_wdata[23:20];
                    m_adr = reg_wdata[19:4]; m_bc = int'(reg_wdata[2:0]);
                    m_wd = keep_bytes({m_wd1, m_wd0}, m_bc);
                end else ns = 4'h3;
            end
            if (be_ack && m_busy) begin
                ns[0] = 1;
                ns[1] = (be_result == 2'd1) || (be_result == 2'd3);
                ns[2] = (be_result == 2'd2);
                nb = 0;
                if (op_rd(m_op) && be_result == 2'd0) begin
                    logic [63:0] k;
                    k = keep_bytes(be_rdata, m_bc);
                    m_rd0 = k[31:0];
                    m_rd1 = k[63:32];
                end
            end
            if (reg_wen && reg_addr == 5'h10) m_wd0 = reg_wdata;
            if (reg_wen && reg_addr == 5'h14) m_wd1 = reg_wdata;
            m_st = ns;
            m_busy = nb;
        end
    end

    // per-clock comparison of the backend port (R8, R2, R5)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(be_valid == m_busy, "R8 be_valid", 64'(be_valid), 64'(m_busy));
            if (m_busy) begin
                chk({be_op, be_sid, be_addr, be_bcnt} == {m_op, m_sid, m_adr, m_bc[2:0]},
                    "R2 backend fields", 64'({be_op, be_sid, be_addr, be_bcnt}),
                    64'({m_op, m_sid, m_adr, m_bc[2:0]}));
                chk(be_wdata == m_wd, "R5 be_wdata", be_wdata, m_wd);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic respond(input logic [1:0] res, input logic [63:0] rd, input int hold);
        while (!be_valid) @(negedge clk);
        repeat (hold) @(negedge clk);
        be_ack = 1'b1; be_result = res; be_rdata = rd;
        @(negedge clk);
        be_ack = 1'b0; be_rdata = '0; be_result = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        rd_chk(5'h08, 32'h0, "R9 status reset");
        rd_chk(5'h04, 32'h0, "R9 config reset");
        rd_chk(5'h18, 32'h0, "R9 rd0 reset");
        rd_chk(5'h1C, 32'h0, "R9 rd1 reset");
        chk(be_valid == 1'b0, "R9 be_valid reset", 64'(be_valid), 64'h0);
        // R1: config and data registers read back
        wr(5'h04, 32'hA5A55A5A);
        rd_chk(5'h04, 32'hA5A55A5A, "R1 config readback");
        rd_chk(5'h0C, 32'h0, "R1 unmapped offset");
        wr(5'h10, 32'h44332211);
        wr(5'h14, 32'h88776655);
        rd_chk(5'h14, 32'h88776655, "R1 wd1 readback");
        // R5: three-byte write, word1 unused
        wr(5'h00, mk(14, 5, 'h1234, 2));
        #1;
        chk(be_wdata == 64'h0000000000332211, "R5 partial write bytes", be_wdata, 64'h332211);
        chk(be_addr == 16'h1234 && be_sid == 4'd5, "R2 field positions",
            64'({be_sid, be_addr}), 64'h51234);
        respond(2'd0, 64'h0, 2);
        rd_chk(5'h08, 32'h1, "R4 ok status");
        // R5/R4: eight-byte write, denied
        wr(5'h00, mk(0, 3, 'h0010, 7));
        #1;
        chk(be_wdata == 64'h8877665544332211, "R5 full write bytes", be_wdata, 64'h8877665544332211);
        respond(2'd2, 64'h0, 0);
        rd_chk(5'h08, 32'h5, "R4 deny status");
        // R6: six-byte read ok
        wr(5'h00, mk(15, 1, 'h0200, 5));
        respond(2'd0, 64'hFFEEDDCCBBAA9988, 3);
        rd_chk(5'h18, 32'hBBAA9988, "R6 rd0 latched");
        rd_chk(5'h1C, 32'h0000DDCC, "R6 rd1 masked");
        rd_chk(5'h08, 32'h1, "R4 read ok status");
        // R6/R4: failed read leaves data
        wr(5'h00, mk(1, 1, 'h0300, 7));
        respond(2'd1, 64'h1111111111111111, 1);
        rd_chk(5'h08, 32'h3, "R4 fail status");
        rd_chk(5'h18, 32'hBBAA9988, "R6 failed read keeps rd0");
        // R4: result 3 maps to failure
        wr(5'h00, mk(13, 2, 'h0400, 0));
        respond(2'd3, 64'hAAAAAAAAAAAAAA77, 0);
        rd_chk(5'h08, 32'h3, "R4 result3 fail");
        // R6: one-byte read, word1 cleared
        wr(5'h00, mk(13, 2, 'h0400, 0));
        respond(2'd0, 64'hAAAAAAAAAAAAAA77, 0);
        rd_chk(5'h18, 32'h00000077, "R6 one byte rd0");
        rd_chk(5'h1C, 32'h0, "R6 one byte rd1");
        // R3/R6: zero write is known, leaves read data
        wr(5'h00, mk(16, 4, 'h0500, 4));
        respond(2'd0, 64'h5555555555555555, 0);
        rd_chk(5'h08, 32'h1, "R3 zero write ok");
        rd_chk(5'h18, 32'h00000077, "R6 write keeps rd0");
        // R3: unknown opcodes
        wr(5'h00, mk(5, 1, 'h0600, 1));
        chk(be_valid == 1'b0, "R3 no request op5", 64'(be_valid), 64'h0);
        rd_chk(5'h08, 32'h3, "R3 unknown op status");
        wr(5'h00, mk(31, 1, 'h0600, 1));
        rd_chk(5'h08, 32'h3, "R3 unknown op31 status");
        // R7: command during flight
        wr(5'h00, mk(15, 2, 'h0456, 3));
        wr(5'h00, mk(14, 9, 'hFFFF, 7));
        rd_chk(5'h08, 32'h9, "R7 dropped status");
        chk(be_addr == 16'h0456, "R7 fields unchanged", 64'(be_addr), 64'h0456);
        respond(2'd0, 64'h0102030405060708, 1);
        rd_chk(5'h08, 32'h9, "R4 dropped kept after ack");
        rd_chk(5'h18, 32'h05060708, "R7 original read completes");
        rd_chk(5'h00, mk(15, 2, 'h0456, 3), "R2 command readback");
        // R10: read-only registers
        wr(5'h08, 32'hFFFFFFFF);
        rd_chk(5'h08, 32'h9, "R10 status write ignored");
        wr(5'h18, 32'hDEADBEEF);
        rd_chk(5'h18, 32'h05060708, "R10 rd0 write ignored");
        wr(5'h1C, 32'hDEADBEEF);
        rd_chk(5'h1C, 32'h0, "R10 rd1 write ignored");
        repeat (2) @(negedge clk);
        summary();
    end

endmodule